// File: doc/BRIEF.md
# Tracking-Filter Capacitor Code Interpolator

This block turns a receive frequency, given in whole MHz, into the control codes for the three capacitor banks of an RF tracking filter: the series bank, the shunt bank and the parallel bank. Each bank has its own calibration values, captured elsewhere at startup and held on the block's inputs. A band-select input picks one of two formulas. The low-band formula moves the calibration code by a fixed slope around a centre frequency. The high-band formula draws a straight line between two calibration points and holds the upper point's value for any frequency above it.

A one-cycle start pulse captures the frequency, the band select and all calibration inputs. The block then computes the three codes one after another. Each division runs on a shared restoring divider that takes several cycles, so there is no wide combinational divide. Each finished code appears on a registered output with a one-cycle valid strobe and a bank index. A done pulse follows the last code. Writing the codes into a register file is left to the surrounding logic.

Top module: `tf_cap_interp`

## Requirements
- R1: After a synchronous reset, `code_vld`, `done` and `busy` are low and `code` is 0.
- R2: With `band_hi`=0, each code equals cal_vhf − floor((f − 195) / 10) in signed arithmetic. The code falls by one count for each 10 MHz above 200 MHz and rises by one for each 10 MHz below it. For example, a calibration of 8 at 208 MHz gives 7.
- R3: Floor division rounds toward minus infinity when the numerator is negative. In the low band, 194 MHz adds 1 to the calibration value and 170 MHz adds 3.
- R4: With `band_hi`=1 and f ≤ 860, each code equals cal_lo − floor(((cal_lo − cal_hi)·(f − 470) + 195) / 390). For example, cal_lo=15 and cal_hi=3 at 677 MHz give 9.
- R5: In the high band, any frequency above 860 MHz gives the same code as 860 MHz, which is cal_hi.
- R6: A result below 0 is output as 0, and a result above 255 is output as 255.
- R7: Each run produces exactly three strobes on `code_vld`, never on adjacent cycles. `code_sel` reads 0, 1 and 2 in that order, meaning series, shunt and parallel. Each code uses the calibration byte of its own bank: bits [7:0] of each calibration port are the series bank, [15:8] the shunt bank and [23:16] the parallel bank.
- R8: `done` pulses for one cycle, on the cycle after the third strobe, and `busy` is low in that cycle.
- R9: A start pulse while `busy` is high is ignored. Changes to `freq`, `band_hi` or the calibration inputs after the capturing start have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures the inputs and begins a run |
| band_hi | input | 1 | 1 selects the high-band line, 0 selects the low-band slope |
| freq | input | 10 | Receive frequency in MHz, unsigned |
| cal_vhf | input | 24 | Low-band calibration codes: series [7:0], shunt [15:8], parallel [23:16] |
| cal_lo | input | 24 | High-band lower-point (470 MHz) codes, packed the same way |
| cal_hi | input | 24 | High-band upper-point (860 MHz) codes, packed the same way |
| code | output | 8 | Capacitor code, valid while code_vld is high |
| code_vld | output | 1 | One-cycle strobe for each bank result |
| code_sel | output | 2 | Bank of the current result: 0 series, 1 shunt, 2 parallel |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the third result |

## Verification
The bench targets negative numerators just below the low-band rounding point. A divider that truncated toward zero would return a code one count low there. It also drives the high band above, at and far beyond 860 MHz, where a missing clamp would keep extrapolating past cal_hi. Calibration values are chosen to push results below 0 and above 255, which a design that wrapped instead of saturating would turn into large or small garbage codes. Each bank gets a distinct calibration byte, so a swapped bank index or out-of-order strobes show up as a wrong code. One run is hit with a second start and new inputs while busy; a design that re-captured them would return codes for the second frequency.

// File: rtl/tfi_pkg.sv
package tfi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} tfi_state_t;
  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIX} div_state_t;
endpackage

// File: rtl/tfi_floor_div.sv
module tfi_floor_div #(
  parameter int NW = 21,
  parameter int DW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic signed [NW-1:0] num,
  input  logic [DW-1:0]        den,
  output logic                 rdy,
  output logic signed [NW-1:0] quo
);
  import tfi_pkg::*;
  localparam int CNTW = $clog2(NW + 1);
  localparam int PW   = NW + DW + 2;

  div_state_t          st;
  logic [NW-1:0]       mag;
  logic [NW-1:0]       qacc;
  logic                neg;
  logic [DW:0]         rem;
  logic [CNTW-1:0]     cnt;
  logic [DW-1:0]       den_q;
  logic signed [NW-1:0] num_q;

  logic [DW:0] rem_sh, rem_nx;
  logic        fits;

  always_comb begin
    rem_sh = {rem[DW-1:0], mag[NW-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= DV_IDLE;
      rdy   <= 1'b0;
      quo   <= '0;
      mag   <= '0;
      qacc  <= '0;
      neg   <= 1'b0;
      rem   <= '0;
      cnt   <= '0;
      den_q <= '0;
      num_q <= '0;
    end else begin
      rdy <= 1'b0;
      case (st)
        DV_IDLE: if (go) begin
          num_q <= num;
          den_q <= den;
          neg   <= num[NW-1];
          mag   <= num[NW-1] ? -num : num;
          rem   <= '0;
          qacc  <= '0;
          cnt   <= CNTW'(NW);
          st    <= DV_RUN;
        end
        DV_RUN: begin
          rem  <= rem_nx;
          qacc <= {qacc[NW-2:0], fits};
          mag  <= {mag[NW-2:0], 1'b0};
          cnt  <= cnt - 1'b1;
          if (cnt == CNTW'(1)) st <= DV_FIX;
        end
        DV_FIX: begin
          quo <= neg ? -$signed(qacc + {{(NW-1){1'b0}}, |rem}) : $signed(qacc);
          rdy <= 1'b1;
          st  <= DV_IDLE;
        end
        default: st <= DV_IDLE;
      endcase
    end
  end

  logic signed [PW-1:0] prod_w, resid_w, den_w;
  always_comb begin
    den_w   = PW'($signed({1'b0, den_q}));
    prod_w  = PW'(quo) * den_w;
    resid_w = PW'(num_q) - prod_w;
  end

  // R3
  floor_rem_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (resid_w >= 0 && resid_w < den_w));
endmodule

// File: rtl/tf_cap_interp.sv
module tf_cap_interp #(
  parameter int FW      = 10,
  parameter int CW      = 8,
  parameter int NCAP    = 3,
  parameter int LB_CTR  = 200,
  parameter int LB_STEP = 10,
  parameter int HB_BASE = 470,
  parameter int HB_SPAN = 390,
  localparam int SW     = $clog2(NCAP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               band_hi,
  input  logic [FW-1:0]      freq,
  input  logic [NCAP*CW-1:0] cal_vhf,
  input  logic [NCAP*CW-1:0] cal_lo,
  input  logic [NCAP*CW-1:0] cal_hi,
  output logic [CW-1:0]      code,
  output logic               code_vld,
  output logic [SW-1:0]      code_sel,
  output logic               busy,
  output logic               done
);
  import tfi_pkg::*;
  localparam int HB_TOP  = HB_BASE + HB_SPAN;
  localparam int LB_BIAS = LB_STEP / 2;
  localparam int HB_BIAS = HB_SPAN / 2;
  localparam int NW      = CW + FW + 3;
  localparam int XW      = NW + 2;
  localparam int DW      = $clog2(HB_SPAN + 1);
  localparam int CMAX    = (1 << CW) - 1;

  tfi_state_t        st;
  logic              band_q;
  logic [FW-1:0]     freq_q;
  logic [NCAP*CW-1:0] vhf_q, lo_q, hi_q;
  logic [SW-1:0]     idx;
  logic              last_q;

  logic [CW-1:0]        cv, clo, chi;
  logic signed [XW-1:0] f_s, fe_s, dcal_s, lb_num, hb_num, base_s, res_s;
  logic signed [NW-1:0] div_num, quo;
  logic [DW-1:0]        div_den;
  logic                 div_go, div_rdy;
  logic [CW-1:0]        sat;

  always_comb begin
    cv      = vhf_q[idx*CW +: CW];
    clo     = lo_q[idx*CW +: CW];
    chi     = hi_q[idx*CW +: CW];
    f_s     = XW'(freq_q);
    fe_s    = (f_s > XW'(HB_TOP)) ? XW'(HB_TOP) : f_s;
    dcal_s  = XW'(clo) - XW'(chi);
    lb_num  = f_s - XW'(LB_CTR - LB_BIAS);
    hb_num  = dcal_s * (fe_s - XW'(HB_BASE)) + XW'(HB_BIAS);
    div_num = band_q ? hb_num[NW-1:0] : lb_num[NW-1:0];
    div_den = band_q ? DW'(HB_SPAN) : DW'(LB_STEP);
    base_s  = band_q ? XW'(clo) : XW'(cv);
    res_s   = base_s - XW'(quo);
    if (res_s < 0)              sat = '0;
    else if (res_s > XW'(CMAX)) sat = CW'(CMAX);
    else                        sat = res_s[CW-1:0];
    div_go  = (st == ST_ISSUE);
  end

  tfi_floor_div #(.NW(NW), .DW(DW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .rdy(div_rdy), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      band_q   <= 1'b0;
      freq_q   <= '0;
      vhf_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      idx      <= '0;
      last_q   <= 1'b0;
      code     <= '0;
      code_vld <= 1'b0;
      code_sel <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      last_q   <= 1'b0;
      done     <= last_q;
      case (st)
        ST_IDLE: if (start) begin
          band_q <= band_hi;
          freq_q <= freq;
          vhf_q  <= cal_vhf;
          lo_q   <= cal_lo;
          hi_q   <= cal_hi;
          idx    <= '0;
          busy   <= 1'b1;
          st     <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (div_rdy) begin
          code     <= sat;
          code_vld <= 1'b1;
          code_sel <= idx;
          if (idx == SW'(NCAP - 1)) begin
            last_q <= 1'b1;
            busy   <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |=> !code_vld);
  // R7
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> (int'(code_sel) < NCAP));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !code_vld);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(freq_q) && $stable(band_q) && $stable(vhf_q));
endmodule

// File: tb/tb_tf_cap_interp.sv
module tb_tf_cap_interp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        band_hi = 1'b0;
  logic [9:0]  freq = '0;
  logic [23:0] cal_vhf = '0, cal_lo = '0, cal_hi = '0;
  logic [7:0]  code;
  logic        code_vld;
  logic [1:0]  code_sel;
  logic        busy, done;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  tf_cap_interp dut (
    .clk(clk), .rst(rst), .start(start), .band_hi(band_hi), .freq(freq),
    .cal_vhf(cal_vhf), .cal_lo(cal_lo), .cal_hi(cal_hi), .code(code),
    .code_vld(code_vld), .code_sel(code_sel), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(int n, int d);
    int q = n / d;
    if ((n % d != 0) && (n < 0)) q--;
    return q;
  endfunction

  function automatic int model(bit hb, int f, int v, int lo, int hi);
    int r, fe;
    if (!hb) r = v - fdiv(f - 195, 10);
    else begin
      fe = (f > 860) ? 860 : f;
      r = lo - fdiv((lo - hi) * (fe - 470) + 195, 390);
    end
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic run_job(bit hb, int f, logic [23:0] v, logic [23:0] lo,
                         logic [23:0] hi, string req, bit poke);
    int exp;
    int n;
    @(negedge clk);
    band_hi = hb; freq = 10'(f); cal_vhf = v; cal_lo = lo; cal_hi = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: second start with different inputs while busy
      chk(busy == 1'b1, "R9", int'(busy), 1);
      band_hi = ~hb; freq = 10'(f + 77); cal_vhf = ~v; cal_lo = ~lo; cal_hi = ~hi;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      n = 0;
      @(negedge clk);
      while (!code_vld && n < 300) begin
        @(negedge clk);
        n++;
      end
      exp = model(hb, f, int'(v[k*8 +: 8]), int'(lo[k*8 +: 8]), int'(hi[k*8 +: 8]));
      chk(code_vld == 1'b1, "R7", int'(code_vld), 1);
      chk(code_sel == 2'(k), "R7", int'(code_sel), k);
      chk(code == 8'(exp), req, int'(code), exp);
    end
    @(negedge clk);
    chk(done == 1'b1, "R8", int'(done), 1);
    chk(busy == 1'b0, "R8", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(code_vld == 1'b0, "R1", int'(code_vld), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(code == 8'd0, "R1", int'(code), 0);

    // R2: 8 at 208 gives 7; other banks distinct (R7)
    run_job(1'b0, 208, {8'd100, 8'd20, 8'd8}, 24'h0, 24'h0, "R2", 1'b0);
    run_job(1'b0, 230, {8'd50, 8'd40, 8'd30}, 24'h0, 24'h0, "R2", 1'b0);
    // R3: negative numerators
    run_job(1'b0, 194, {8'd12, 8'd11, 8'd10}, 24'h0, 24'h0, "R3", 1'b0);
    run_job(1'b0, 170, {8'd90, 8'd60, 8'd10}, 24'h0, 24'h0, "R3", 1'b0);
    run_job(1'b0, 195, {8'd3, 8'd2, 8'd1}, 24'h0, 24'h0, "R3", 1'b0);
    // R4: 15/3 at 677 gives 9
    run_job(1'b1, 677, 24'h0, {8'd200, 8'd40, 8'd15}, {8'd10, 8'd90, 8'd3}, "R4", 1'b0);
    run_job(1'b1, 470, 24'h0, {8'd7, 8'd8, 8'd9}, {8'd1, 8'd2, 8'd3}, "R4", 1'b0);
    // R5: clamp above 860
    run_job(1'b1, 860, 24'h0, {8'd30, 8'd20, 8'd15}, {8'd4, 8'd5, 8'd3}, "R5", 1'b0);
    run_job(1'b1, 900, 24'h0, {8'd30, 8'd20, 8'd15}, {8'd4, 8'd5, 8'd3}, "R5", 1'b0);
    run_job(1'b1, 1023, 24'h0, {8'd0, 8'd255, 8'd15}, {8'd255, 8'd0, 8'd3}, "R5", 1'b0);
    // R6: saturation both ways
    run_job(1'b0, 230, {8'd254, 8'd1, 8'd0}, 24'h0, 24'h0, "R6", 1'b0);
    run_job(1'b0, 170, {8'd254, 8'd253, 8'd0}, 24'h0, 24'h0, "R6", 1'b0);
    run_job(1'b1, 300, 24'h0, {8'd0, 8'd255, 8'd255}, {8'd255, 8'd0, 8'd0}, "R6", 1'b0);
    // R9: start while busy ignored, input changes ignored
    run_job(1'b0, 208, {8'd77, 8'd44, 8'd8}, 24'h0, 24'h0, "R9", 1'b1);
    run_job(1'b1, 677, 24'h0, {8'd99, 8'd60, 8'd15}, {8'd1, 8'd30, 8'd3}, "R9", 1'b1);

    // Random mix (R2, R4)
    for (int i = 0; i < 40; i++) begin
      bit hb = 1'($urandom);
      int f = hb ? int'($urandom_range(1023, 400)) : int'($urandom_range(260, 150));
      run_job(hb, f, 24'($urandom), 24'($urandom), 24'($urandom),
              hb ? "R4" : "R2", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule